// File: doc/BRIEF.md
# CPU Bus Address Decoder with Sprite-Page DMA

This block sits between an 8-bit processor core and the rest of a games-console-style system. It takes each request on a 16-bit address bus and steers it to one target. The internal 2 KB work RAM lives inside the block. The picture-processor register file, the I/O and audio registers, the optional battery-backed cartridge RAM, the mapper register port and a banked program ROM are reached through select strobes and index fields. Address bits that a target ignores are dropped, so the small regions repeat across their larger windows.

A processor write to the sprite-DMA register starts a copy engine. The engine moves one 256-byte page of work RAM into sprite memory, one byte per cycle. The first byte lands at the sprite pointer the picture processor supplies, and each later byte goes to the next pointer value, wrapping at 8 bits. While the copy runs the block raises `busy`. Requests offered during that time are not accepted, and the processor is expected to hold them until `busy` falls.

Read data from every target comes back exactly one cycle after the request, with a valid pulse. Program ROM is a synchronous memory outside the block, and its output is passed through in that same cycle, so all targets show the same latency.

Top module: `cpu_bus_decoder`

## Requirements
- R1: A request below 0x2000 reaches work RAM at index addr[10:0], so any two addresses below 0x2000 that differ only in bits 12:11 hit the same byte. A read returns its data on `cpuRdData` in the cycle after the request, with `cpuRdValid` high for that one cycle.
- R2: A request in 0x2000–0x3FFF raises `ppuSel` with `ppuReg` = addr[2:0]. A read returns the `ppuRdData` that was present during the request cycle.
- R3: A request in 0x4000–0x4017, other than a write to 0x4014, raises `ioSel` with `ioReg` = addr[4:0]. A read of 0x4016 returns `padRdData`, and a read of any other address in that range returns 0.
- R4: A request in 0x6000–0x7FFF raises `cartSel` with `cartAddr` = addr[12:0] only when `hasCartRam` is 1, and a read then returns `cartRdData`. When `hasCartRam` is 0, no select is raised and a read returns 0.
- R5: A read at 0x8000 or above raises `romSel` with `romBank` = addr[14:10] and `romOffset` = addr[9:0], and returns `romRdData` in the following cycle. `romSel` is never raised for a write.
- R6: A write at 0x8000 or above raises `mapperSel` with `mapperAddr` = addr[14:0] when `mapperType` is nonzero. When `mapperType` is 0, the write raises no select at all.
- R7: A write of value V to 0x4014 copies 256 bytes into sprite memory. Byte i comes from work RAM index {V[2:0], i[7:0]} and goes to `sprWrAddr` = (P + i) mod 256, where P is `sprAddrIn` at the moment of the trigger.
- R8: `busy` rises in the cycle after the trigger and stays high for exactly 257 cycles. While `busy` is high, requests raise no select and change no RAM byte. The trigger write itself raises no select.
- R9: Requests in 0x4018–0x5FFF raise no select, and reads there return 0.
- R10: During and after reset, `busy`, `cpuRdValid`, `sprWrEn` and every select are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request valid |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Request address |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data, one cycle after the request |
| cpuRdValid | output | 1 | Read data valid |
| busy | output | 1 | DMA copy in progress; requests are not accepted |
| mapperType | input | 3 | Mapper kind; nonzero diverts high writes |
| hasCartRam | input | 1 | Cartridge RAM fitted |
| busWe | output | 1 | Accepted request is a write |
| busWrData | output | 8 | Write data toward targets |
| ppuSel | output | 1 | Picture-processor register select |
| ppuReg | output | 3 | Picture-processor register index |
| ppuRdData | input | 8 | Picture-processor read data (same cycle) |
| ioSel | output | 1 | I/O and audio register select |
| ioReg | output | 5 | I/O register index |
| padRdData | input | 8 | Controller port read data (same cycle) |
| cartSel | output | 1 | Cartridge RAM select |
| cartAddr | output | 13 | Cartridge RAM index |
| cartRdData | input | 8 | Cartridge RAM read data (same cycle) |
| romSel | output | 1 | Program ROM read select |
| romBank | output | 5 | 1 KB ROM bank index |
| romOffset | output | 10 | Byte offset inside the bank |
| romRdData | input | 8 | ROM data, one cycle after `romSel` |
| mapperSel | output | 1 | Mapper register write strobe |
| mapperAddr | output | 15 | Mapper register address |
| sprAddrIn | input | 8 | Current sprite memory pointer |
| sprWrEn | output | 1 | Sprite memory write strobe |
| sprWrAddr | output | 8 | Sprite memory write address |
| sprWrData | output | 8 | Sprite memory write data |

## Verification
Random addresses are drawn per region, and also across region edges such as 0x1FFF/0x2000, 0x4017/0x4018 and 0x7FFF/0x8000. They run under every combination of cartridge RAM present or absent and mapper type zero or nonzero, so each rule for select, index and read-back is separated from its neighbours. Work RAM is first filled through addresses that vary bits 12:11 and is then read back through other mirrors, which shows whether all four aliases reach one cell. DMA runs use pages above 7 and starting pointers of 0 and 0xF0. These separate page masking and pointer wrap from a straight copy. A write offered mid-copy shows whether stalled requests leak through.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int RAM_AW  = 11;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_PPU,
    TGT_PAD,
    TGT_CART,
    TGT_ROM
  } rdTgt_e;

  typedef struct packed {
    logic              ramEn;
    logic              ramWe;
    logic [RAM_AW-1:0] ramAddr;
    logic [DATA_W-1:0] ramWrData;
    logic              rdReq;
    rdTgt_e            rdTgt;
  } ctrlStrobe_t;
endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
#(
  parameter int          DMA_LEN   = 256,
  parameter logic [15:0] DMA_REG   = 16'h4014,
  parameter logic [15:0] PAD_REG   = 16'h4016,
  parameter logic [15:0] PPU_BASE  = 16'h2000,
  parameter logic [15:0] IO_BASE   = 16'h4000,
  parameter logic [15:0] IO_END    = 16'h4018,
  parameter logic [15:0] CART_BASE = 16'h6000,
  parameter logic [15:0] ROM_BASE  = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [2:0]        mapperType,
  input  logic              hasCartRam,
  input  logic [7:0]        sprAddrIn,
  output ctrlStrobe_t       strobe,
  output logic              busy,
  output logic              busWe,
  output logic [DATA_W-1:0] busWrData,
  output logic              ppuSel,
  output logic [2:0]        ppuReg,
  output logic              ioSel,
  output logic [4:0]        ioReg,
  output logic              cartSel,
  output logic [12:0]       cartAddr,
  output logic              romSel,
  output logic [4:0]        romBank,
  output logic [9:0]        romOffset,
  output logic              mapperSel,
  output logic [14:0]       mapperAddr,
  output logic              sprWrEn,
  output logic [7:0]        sprWrAddr
);
  localparam int CNT_W  = $clog2(DMA_LEN);
  localparam int PAGE_W = RAM_AW - CNT_W;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DMA_LEN - 1);

  logic              dmaActive;
  logic              wrStage;
  logic [CNT_W-1:0]  rdCnt;
  logic [CNT_W-1:0]  wrIdx;
  logic [PAGE_W-1:0] pageQ;
  logic [7:0]        sprBase;
  logic              accept;
  logic              dmaGo;

  assign busy      = dmaActive | wrStage;
  assign accept    = cpuReq & ~busy;
  assign busWe     = accept & cpuWr;
  assign busWrData = cpuWrData;

  assign ppuReg     = cpuAddr[2:0];
  assign ioReg      = cpuAddr[4:0];
  assign cartAddr   = cpuAddr[12:0];
  assign romBank    = cpuAddr[14:10];
  assign romOffset  = cpuAddr[9:0];
  assign mapperAddr = cpuAddr[14:0];

  // Address decode of the accepted request, with DMA reads taking the RAM port.
  always_comb begin
    strobe           = '0;
    strobe.rdTgt     = TGT_NONE;
    strobe.ramWrData = cpuWrData;
    ppuSel    = 1'b0;
    ioSel     = 1'b0;
    cartSel   = 1'b0;
    romSel    = 1'b0;
    mapperSel = 1'b0;
    dmaGo     = 1'b0;
    if (accept) begin
      strobe.rdReq = ~cpuWr;
      if (cpuAddr < PPU_BASE) begin
        strobe.ramEn   = 1'b1;
        strobe.ramWe   = cpuWr;
        strobe.ramAddr = cpuAddr[RAM_AW-1:0];
        strobe.rdTgt   = TGT_RAM;
      end else if (cpuAddr < IO_BASE) begin
        ppuSel       = 1'b1;
        strobe.rdTgt = TGT_PPU;
      end else if (cpuAddr < IO_END) begin
        if (cpuWr && cpuAddr == DMA_REG) begin
          dmaGo = 1'b1;
        end else begin
          ioSel        = 1'b1;
          strobe.rdTgt = (cpuAddr == PAD_REG) ? TGT_PAD : TGT_NONE;
        end
      end else if (cpuAddr < CART_BASE) begin
        strobe.rdTgt = TGT_NONE;
      end else if (cpuAddr < ROM_BASE) begin
        if (hasCartRam) begin
          cartSel      = 1'b1;
          strobe.rdTgt = TGT_CART;
        end
      end else if (cpuWr) begin
        mapperSel = (mapperType != 3'd0);
      end else begin
        romSel       = 1'b1;
        strobe.rdTgt = TGT_ROM;
      end
    end
    if (dmaActive) begin
      strobe.ramEn   = 1'b1;
      strobe.ramWe   = 1'b0;
      strobe.ramAddr = {pageQ, rdCnt};
    end
  end

  // DMA sequencer: read stage then sprite-write stage, one byte per cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaActive <= 1'b0;
      wrStage   <= 1'b0;
      rdCnt     <= '0;
      wrIdx     <= '0;
      pageQ     <= '0;
      sprBase   <= '0;
    end else begin
      wrStage <= dmaActive;
      wrIdx   <= rdCnt;
      if (dmaGo) begin
        dmaActive <= 1'b1;
        rdCnt     <= '0;
        pageQ     <= cpuWrData[PAGE_W-1:0];
        sprBase   <= sprAddrIn;
      end else if (dmaActive) begin
        rdCnt <= rdCnt + 1'b1;
        if (rdCnt == LAST_IDX) dmaActive <= 1'b0;
      end
    end
  end

  assign sprWrEn   = wrStage;
  assign sprWrAddr = sprBase + 8'(wrIdx);

  // Length of the current busy window, used by the R8 check.
  logic [9:0] busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  a_r8_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == 10'(DMA_LEN + 1));

  a_r8_no_sel_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(ppuSel || ioSel || cartSel || romSel || mapperSel || busWe));

  a_r5_rom_read_only: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> !busWe);

  a_r6_mapper_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    mapperSel |-> (busWe && mapperType != 3'd0));

  a_r4_cart_present: assert property (@(posedge clk) disable iff (!rstN)
    cartSel |-> hasCartRam);

  a_r7_spr_step: assert property (@(posedge clk) disable iff (!rstN)
    (sprWrEn && $past(sprWrEn)) |-> sprWrAddr == $past(sprWrAddr) + 8'd1);

  a_r2_single_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ppuSel, ioSel, cartSel, romSel, mapperSel}));
endmodule

// File: rtl/busdec_dpath.sv
module busdec_dpath
  import busdec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] ppuRdData,
  input  logic [DATA_W-1:0] padRdData,
  input  logic [DATA_W-1:0] cartRdData,
  input  logic [DATA_W-1:0] romRdData,
  output logic [DATA_W-1:0] ramQ,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuRdValid
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] workRam [RAM_DEPTH];
  logic [DATA_W-1:0] extQ;
  rdTgt_e            tgtQ;

  always_ff @(posedge clk) begin
    if (strobe.ramEn) begin
      if (strobe.ramWe) workRam[strobe.ramAddr] <= strobe.ramWrData;
      else              ramQ <= workRam[strobe.ramAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdValid <= 1'b0;
      tgtQ       <= TGT_NONE;
      extQ       <= '0;
    end else begin
      cpuRdValid <= strobe.rdReq;
      if (strobe.rdReq) begin
        tgtQ <= strobe.rdTgt;
        unique case (strobe.rdTgt)
          TGT_PPU:  extQ <= ppuRdData;
          TGT_PAD:  extQ <= padRdData;
          TGT_CART: extQ <= cartRdData;
          default:  extQ <= '0;
        endcase
      end
    end
  end

  always_comb begin
    unique case (tgtQ)
      TGT_RAM: cpuRdData = ramQ;
      TGT_ROM: cpuRdData = romRdData;
      default: cpuRdData = extQ;
    endcase
  end

  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdReq |=> cpuRdValid);

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdReq |=> !cpuRdValid);
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import busdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWr,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData,
  output logic        cpuRdValid,
  output logic        busy,
  input  logic [2:0]  mapperType,
  input  logic        hasCartRam,
  output logic        busWe,
  output logic [7:0]  busWrData,
  output logic        ppuSel,
  output logic [2:0]  ppuReg,
  input  logic [7:0]  ppuRdData,
  output logic        ioSel,
  output logic [4:0]  ioReg,
  input  logic [7:0]  padRdData,
  output logic        cartSel,
  output logic [12:0] cartAddr,
  input  logic [7:0]  cartRdData,
  output logic        romSel,
  output logic [4:0]  romBank,
  output logic [9:0]  romOffset,
  input  logic [7:0]  romRdData,
  output logic        mapperSel,
  output logic [14:0] mapperAddr,
  input  logic [7:0]  sprAddrIn,
  output logic        sprWrEn,
  output logic [7:0]  sprWrAddr,
  output logic [7:0]  sprWrData
);
  ctrlStrobe_t strobe;
  logic [7:0]  ramQ;

  busdec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .mapperType(mapperType), .hasCartRam(hasCartRam), .sprAddrIn(sprAddrIn),
    .strobe(strobe), .busy(busy), .busWe(busWe), .busWrData(busWrData),
    .ppuSel(ppuSel), .ppuReg(ppuReg), .ioSel(ioSel), .ioReg(ioReg),
    .cartSel(cartSel), .cartAddr(cartAddr),
    .romSel(romSel), .romBank(romBank), .romOffset(romOffset),
    .mapperSel(mapperSel), .mapperAddr(mapperAddr),
    .sprWrEn(sprWrEn), .sprWrAddr(sprWrAddr)
  );

  busdec_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ppuRdData(ppuRdData), .padRdData(padRdData),
    .cartRdData(cartRdData), .romRdData(romRdData),
    .ramQ(ramQ), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid)
  );

  assign sprWrData = ramQ;

  a_r10_idle_after_reset: assert property (@(posedge clk)
    !rstN |=> !(busy || cpuRdValid || sprWrEn || ppuSel || ioSel || cartSel || romSel || mapperSel));
endmodule

// File: tb/sim_cpu_bus_decoder.sv
module sim_cpu_bus_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        cpuReq = 0, cpuWr = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuWrData = 0;
  logic [7:0]  cpuRdData;
  logic        cpuRdValid, busy;
  logic [2:0]  mapperType = 0;
  logic        hasCartRam = 0;
  logic        busWe;
  logic [7:0]  busWrData;
  logic        ppuSel, ioSel, cartSel, romSel, mapperSel;
  logic [2:0]  ppuReg;
  logic [4:0]  ioReg;
  logic [12:0] cartAddr;
  logic [4:0]  romBank;
  logic [9:0]  romOffset;
  logic [14:0] mapperAddr;
  logic [7:0]  ppuRdData, cartRdData;
  logic [7:0]  padRdData = 8'h41;
  logic [7:0]  romRdData = 8'h00;
  logic [7:0]  sprAddrIn = 0;
  logic        sprWrEn;
  logic [7:0]  sprWrAddr, sprWrData;

  cpu_bus_decoder u0 (.*);

  function automatic logic [7:0] ppuFn(input logic [2:0] r);
    return {5'b10110, r};
  endfunction
  function automatic logic [7:0] cartFn(input logic [12:0] a);
    return a[7:0] ^ {3'b0, a[12:8]};
  endfunction
  function automatic logic [7:0] romFn(input logic [4:0] b, input logic [9:0] o);
    return {b, 3'b101} ^ o[7:0] ^ {6'b0, o[9:8]};
  endfunction

  assign ppuRdData  = ppuFn(ppuReg);
  assign cartRdData = cartFn(cartAddr);
  always @(posedge clk) if (romSel) romRdData <= romFn(romBank, romOffset);

  logic [7:0] sprMdl [256];
  always @(posedge clk) if (sprWrEn) sprMdl[sprWrAddr] <= sprWrData;

  logic [7:0] ramMdl [2048];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected select vector {ppu, io, cart, rom, mapper}
  function automatic logic [4:0] expSel(input logic [15:0] a, input logic wr);
    if (a < 16'h2000) return 5'b00000;
    if (a < 16'h4000) return 5'b10000;
    if (a < 16'h4018) return (wr && a == 16'h4014) ? 5'b00000 : 5'b01000;
    if (a < 16'h6000) return 5'b00000;
    if (a < 16'h8000) return hasCartRam ? 5'b00100 : 5'b00000;
    if (wr) return (mapperType != 0) ? 5'b00001 : 5'b00000;
    return 5'b00010;
  endfunction

  function automatic logic [7:0] expRd(input logic [15:0] a);
    if (a < 16'h2000) return ramMdl[a[10:0]];
    if (a < 16'h4000) return ppuFn(a[2:0]);
    if (a < 16'h4018) return (a == 16'h4016) ? padRdData : 8'h00;
    if (a < 16'h6000) return 8'h00;
    if (a < 16'h8000) return hasCartRam ? cartFn(a[12:0]) : 8'h00;
    return romFn(a[14:10], a[9:0]);
  endfunction

  function automatic string reqOf(input logic [15:0] a, input logic wr);
    if (a < 16'h2000) return "R1";
    if (a < 16'h4000) return "R2";
    if (a < 16'h4018) return "R3";
    if (a < 16'h6000) return "R9";
    if (a < 16'h8000) return "R4";
    return wr ? "R6" : "R5";
  endfunction

  task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] d);
    logic [4:0] sel;
    logic [7:0] exp;
    string rq;
    rq = reqOf(a, wr);
    @(negedge clk);
    cpuReq = 1; cpuWr = wr; cpuAddr = a; cpuWrData = d;
    #1;
    sel = {ppuSel, ioSel, cartSel, romSel, mapperSel};
    check(sel == expSel(a, wr), rq, sel, expSel(a, wr));
    if (ppuSel)    check(ppuReg == a[2:0], "R2", ppuReg, a[2:0]);
    if (ioSel)     check(ioReg == a[4:0], "R3", ioReg, a[4:0]);
    if (cartSel)   check(cartAddr == a[12:0], "R4", cartAddr, a[12:0]);
    if (romSel)    check({romBank, romOffset} == a[14:0], "R5", {romBank, romOffset}, a[14:0]);
    if (mapperSel) check(mapperAddr == a[14:0], "R6", mapperAddr, a[14:0]);
    exp = expRd(a);
    @(negedge clk);
    cpuReq = 0;
    check(cpuRdValid == !wr, "R1", cpuRdValid, !wr);
    if (!wr) check(cpuRdData == exp, rq, cpuRdData, exp);
    if (wr && a < 16'h2000) ramMdl[a[10:0]] = d;
  endtask

  function automatic logic [15:0] randAddr();
    case ($urandom % 7)
      0: return 16'($urandom % 16'h2000);
      1: return 16'h2000 + 16'($urandom % 16'h2000);
      2: return 16'h4000 + 16'($urandom % 16'h18);
      3: return 16'h4018 + 16'($urandom % 16'h1FE8);
      4: return 16'h6000 + 16'($urandom % 16'h2000);
      5: return 16'h8000 | 16'($urandom % 16'h8000);
      default: begin
        logic [15:0] edges [6] = '{16'h1FFF, 16'h2000, 16'h4017, 16'h4018, 16'h7FFF, 16'h8000};
        return edges[$urandom % 6];
      end
    endcase
  endfunction

  task automatic runDma(input logic [7:0] v, input logic [7:0] ptr);
    int n;
    bit sprOk;
    int badI;
    sprAddrIn = ptr;
    @(negedge clk);
    cpuReq = 1; cpuWr = 1; cpuAddr = 16'h4014; cpuWrData = v;
    #1;
    check({ppuSel, ioSel, cartSel, romSel, mapperSel} == 5'b0, "R8", ioSel, 0);
    @(negedge clk);
    cpuReq = 0;
    sprAddrIn = ~ptr;  // pointer must have been latched at the trigger
    n = 0;
    while (busy && n < 400) begin
      n++;
      if (n == 7) begin
        cpuReq = 1; cpuWr = 1; cpuAddr = 16'h0123; cpuWrData = ~ramMdl[11'h123];
        #1;
        check({ppuSel, ioSel, cartSel, romSel, mapperSel, busWe} == 6'b0, "R8", busWe, 0);
      end else cpuReq = 0;
      @(negedge clk);
    end
    cpuReq = 0;
    check(n == 257, "R8", n, 257);
    sprOk = 1; badI = 0;
    for (int i = 0; i < 256; i++)
      if (sprOk && sprMdl[8'(ptr + i)] !== ramMdl[{v[2:0], 8'(i)}]) begin
        sprOk = 0; badI = i;
      end
    check(sprOk, "R7", sprMdl[8'(ptr + badI)], ramMdl[{v[2:0], 8'(badI)}]);
    access(16'h0123, 1'b0, 8'h00);  // ignored write must not show (R8)
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check({busy, cpuRdValid, sprWrEn, ppuSel, ioSel, cartSel, romSel, mapperSel} == 8'b0,
          "R10", {busy, cpuRdValid, sprWrEn}, 0);
    rstN = 1;
    // R1: fill work RAM through varying mirrors, then read back through others
    for (int i = 0; i < 2048; i++) access(16'(i + 16'h800 * (i % 4)), 1'b1, 8'($urandom));
    for (int i = 0; i < 64; i++) begin
      logic [15:0] a = 16'($urandom % 16'h800);
      access(a | 16'h1800, 1'b0, 8'h00);
      access(a | 16'h0800, 1'b0, 8'h00);
    end
    // Directed edges
    access(16'h4016, 1'b0, 0);  // R3 controller
    access(16'h4015, 1'b0, 0);  // R3 audio reads 0
    access(16'h3FFF, 1'b0, 0);  // R2 mirrored register 7
    access(16'h4018, 1'b0, 0);  // R9
    access(16'hFFFC, 1'b0, 0);  // R5
    // Random over config combinations (R2..R6, R9)
    for (int cfg = 0; cfg < 4; cfg++) begin
      hasCartRam = cfg[0];
      mapperType = cfg[1] ? 3'd4 : 3'd0;
      for (int k = 0; k < 150; k++) begin
        logic [15:0] a = randAddr();
        logic wr = ($urandom % 3 == 0);
        if (wr && a == 16'h4014) a = 16'h4015;
        access(a, wr, 8'($urandom));
      end
    end
    // R7 / R8 DMA runs
    runDma(8'h02, 8'h00);
    runDma(8'h0D, 8'hF0);   // page masked to 5, pointer wraps
    runDma(8'h07, 8'h81);
    access(16'h0200, 1'b0, 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule